// File: doc/BRIEF.md
# Frame Relocation Controller

This controller relocates a reconfigurable region by way of an on-chip frame store. A copy operation pulls the frames of a source region out through a 32-bit configuration access port and writes them into the store. A configure operation later writes the stored frames into a destination region. The store holds one whole region, so a single copy can be replayed into any number of destination regions.

Reads are strictly one frame per pass. Each frame gets its own synchronisation sequence, its data reads and its desynchronisation sequence. Writes go out in multi-frame bursts, one burst per chunk taken from a short list of chunk lengths. Only the first frame address of a chunk is sent, because the port advances the frame address by itself. Every command sequence is first built in a small command buffer and then streamed to the port. A fixed port start-up wait is inserted before every command or data stream. When the destination lies in the opposite half of the device, each stored word is bit-reversed on its way out.

The command side uses plain pins: start, busy and done. The port has no back-pressure. It takes one word on every cycle in which the enable is high. On a read cycle it returns its data in that same cycle.

Top module: `frame_reloc_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and cfg_en_o are low.
- R2: A copy of N frames (op_i=0) gives, for each frame f in 0..N-1, the following port cycles:
  - three write cycles carrying SYNC_WORD, READ_CMD and start_addr_i+f;
  - FRAME_WORDS read cycles (cfg_wr_o=0), whose data is stored in memory in arrival order;
  - one write cycle carrying DESYNC_WORD.
- R3: Before every command or data stream the port stays idle (cfg_en_o low) for at least STARTUP_LAT cycles. Between the address word and the first data word it stays idle for exactly STARTUP_LAT cycles.
- R4: A configure (op_i=1) goes through chunks 0..chunk_num_i-1 in order. Chunk k has length chunk_len_i[k*LEN_W +: LEN_W]. For each chunk the port sees three write cycles carrying SYNC_WORD, WRITE_CMD and start_addr_i plus the sum of the earlier chunk lengths. Next come len*FRAME_WORDS data writes with no command or address word between them, and then DESYNC_WORD.
- R5: Configure data words are the stored words in memory order, starting at the first word of the store for every operation. The store keeps its contents between operations, so one copy can be replayed several times.
- R6: When opp_half_i is set at start, every configure data word is bit-reversed (bit i goes to bit 31-i). Command and address words are never reversed.
- R7: A copy with frame_cnt_i=0, a configure with chunk_num_i=0, and chunks of length zero all produce no port activity. Zero-length chunks are skipped and do not shift the addresses of later chunks. An operation with nothing to move still completes with done.
- R8: A start_i pulse while busy_o is high is ignored. The operation in progress goes on unchanged, and no second operation follows it.
- R9: done_o is high for exactly one cycle at the end of each operation, after the final desynchronisation word. busy_o is low in that cycle, and the port stays idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 1 | 0 = copy region to store, 1 = configure region from store |
| start_addr_i | input | 32 | Source (copy) or destination (configure) first frame address |
| frame_cnt_i | input | 5 | Number of frames to copy |
| chunk_num_i | input | 3 | Number of entries in the chunk list |
| chunk_len_i | input | 24 | Chunk lengths in frames, entry k at bits k*6 +: 6 |
| opp_half_i | input | 1 | Bit-reverse configure data words |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_en_o | output | 1 | Port access enable |
| cfg_wr_o | output | 1 | 1 = write cycle, 0 = read cycle |
| cfg_wdata_o | output | 32 | Word written to the port |
| cfg_rdata_i | input | 32 | Word read from the port in a read cycle |

## Verification
Some properties are checked on every cycle. Read cycles happen only during a copy. The port is silent whenever the block is not busy. done is a single-cycle pulse that never overlaps busy. The command buffer never overflows or underflows, and a start while busy leaves the latched operation untouched. Other behaviour only the directed scenarios can show, with the bench's port model and expected store image: the exact command order, the per-chunk addressing with zero-length chunks skipped, the start-up idle gaps, the replay of stored data and the bit reversal.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int WORD_W = 32;
  localparam int SYNC_SEQ_LEN = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_GSYNC, S_WSYNC, S_SYNC,
    S_WDATA, S_DATA, S_GDES, S_WDES, S_DES
  } frc_state_e;

  typedef enum logic {OP_COPY = 1'b0, OP_CONFIG = 1'b1} frc_op_e;

  function automatic logic [WORD_W-1:0] mirror_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/frc_cmd_buf.sv
module frc_cmd_buf #(
  parameter int DEPTH = 4,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         last_o
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVW = $clog2(DEPTH + 1);

  logic [W-1:0]   slot [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [LVW-1:0] level;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_i) begin
        slot[wr_ptr] <= push_data_i;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_i) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push_i && !pop_i) level <= level + 1'b1;
      else if (pop_i && !push_i) level <= level - 1'b1;
    end
  end

  assign head_o = slot[rd_ptr];
  assign last_o = (level == LVW'(1));

  // R2 R4: command sequences always fit the buffer and are never over-read
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (level < LVW'(DEPTH)));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (level != '0));
endmodule

// File: rtl/frc_frame_mem.sv
module frc_frame_mem #(
  parameter int DEPTH = 64,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  assign rdata_o = store[raddr_i];
endmodule

// File: rtl/frame_reloc_ctrl.sv
module frame_reloc_ctrl
  import frc_pkg::*;
#(
  parameter int FRAME_WORDS = 4,
  parameter int MAX_FRAMES  = 16,
  parameter int MAX_CHUNKS  = 4,
  parameter int LEN_W       = 6,
  parameter int STARTUP_LAT = 2,
  parameter logic [31:0] SYNC_WORD   = 32'hAA99_5566,
  parameter logic [31:0] READ_CMD    = 32'h2800_6000,
  parameter logic [31:0] WRITE_CMD   = 32'h3000_4000,
  parameter logic [31:0] DESYNC_WORD = 32'h0000_000D,
  localparam int CNT_W = $clog2(MAX_FRAMES + 1),
  localparam int CH_W  = $clog2(MAX_CHUNKS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        op_i,
  input  logic [31:0]                 start_addr_i,
  input  logic [CNT_W-1:0]            frame_cnt_i,
  input  logic [CH_W-1:0]             chunk_num_i,
  input  logic [MAX_CHUNKS*LEN_W-1:0] chunk_len_i,
  input  logic                        opp_half_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        cfg_en_o,
  output logic                        cfg_wr_o,
  output logic [31:0]                 cfg_wdata_o,
  input  logic [31:0]                 cfg_rdata_i
);
  localparam int MEM_DEPTH = MAX_FRAMES * FRAME_WORDS;
  localparam int MAW  = $clog2(MEM_DEPTH);
  localparam int CI_W = $clog2(MAX_CHUNKS);
  localparam int DW   = LEN_W + $clog2(FRAME_WORDS + 1);
  localparam int LW   = $clog2(STARTUP_LAT + 1);

  frc_state_e         state;
  frc_op_e            op_q;
  logic [31:0]        base_q, cur_addr_q, off_q;
  logic [CNT_W-1:0]   cnt_q, frame_idx;
  logic [CH_W-1:0]    nch_q, ch_idx;
  logic [LEN_W-1:0]   lens_q [MAX_CHUNKS];
  logic               opp_q, done_q;
  logic [DW-1:0]      unit_words, dcnt;
  logic [MAW-1:0]     mem_ptr;
  logic [LW-1:0]      lat_cnt;
  logic [1:0]         gen_cnt;

  logic [LEN_W-1:0]   cur_len;
  logic               lat_end, buf_last, buf_push, buf_pop, buf_clr;
  logic [31:0]        gen_word, buf_head, mem_rdata, data_word;

  assign cur_len  = (ch_idx < CH_W'(MAX_CHUNKS)) ? lens_q[ch_idx[CI_W-1:0]] : '0;
  assign lat_end  = (lat_cnt == LW'(STARTUP_LAT - 1));
  assign buf_push = (state == S_GSYNC) || (state == S_GDES);
  assign buf_pop  = (state == S_SYNC) || (state == S_DES);
  assign buf_clr  = (state == S_IDLE) && start_i;

  always_comb begin
    gen_word = '0;
    if (state == S_GSYNC) begin
      case (gen_cnt)
        2'd0:    gen_word = SYNC_WORD;
        2'd1:    gen_word = (op_q == OP_COPY) ? READ_CMD : WRITE_CMD;
        default: gen_word = cur_addr_q;
      endcase
    end else if (state == S_GDES) begin
      gen_word = DESYNC_WORD;
    end
  end

  frc_cmd_buf #(.DEPTH(SYNC_SEQ_LEN + 1), .W(32)) u_cmd_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr),
    .push_i(buf_push), .push_data_i(gen_word),
    .pop_i(buf_pop), .head_o(buf_head), .last_o(buf_last)
  );

  frc_frame_mem #(.DEPTH(MEM_DEPTH), .W(32)) u_mem (
    .clk(clk),
    .we_i((state == S_DATA) && (op_q == OP_COPY)),
    .waddr_i(mem_ptr), .wdata_i(cfg_rdata_i),
    .raddr_i(mem_ptr), .rdata_o(mem_rdata)
  );

  generate
    if (1) begin : g_out_path
      assign data_word = opp_q ? mirror_word(mem_rdata) : mem_rdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q <= OP_COPY;
      base_q <= '0; cur_addr_q <= '0; off_q <= '0;
      cnt_q <= '0; frame_idx <= '0; nch_q <= '0; ch_idx <= '0;
      for (int k = 0; k < MAX_CHUNKS; k++) lens_q[k] <= '0;
      opp_q <= 1'b0; done_q <= 1'b0;
      unit_words <= '0; dcnt <= '0; mem_ptr <= '0;
      lat_cnt <= '0; gen_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          op_q <= frc_op_e'(op_i);
          base_q <= start_addr_i;
          cnt_q <= frame_cnt_i;
          nch_q <= chunk_num_i;
          for (int k = 0; k < MAX_CHUNKS; k++) lens_q[k] <= chunk_len_i[k*LEN_W +: LEN_W];
          opp_q <= opp_half_i && op_i;
          frame_idx <= '0; ch_idx <= '0; off_q <= '0; mem_ptr <= '0;
          state <= S_NEXT;
        end
        S_NEXT: begin
          gen_cnt <= '0;
          if (op_q == OP_COPY) begin
            if (frame_idx == cnt_q) begin
              done_q <= 1'b1;
              state <= S_IDLE;
            end else begin
              cur_addr_q <= base_q + 32'(frame_idx);
              unit_words <= DW'(FRAME_WORDS);
              state <= S_GSYNC;
            end
          end else if (ch_idx >= nch_q || ch_idx >= CH_W'(MAX_CHUNKS)) begin
            done_q <= 1'b1;
            state <= S_IDLE;
          end else if (cur_len == '0) begin
            ch_idx <= ch_idx + 1'b1;
          end else begin
            cur_addr_q <= base_q + off_q;
            unit_words <= DW'(cur_len) * DW'(FRAME_WORDS);
            state <= S_GSYNC;
          end
        end
        S_GSYNC: begin
          gen_cnt <= gen_cnt + 1'b1;
          if (gen_cnt == 2'(SYNC_SEQ_LEN - 1)) begin
            lat_cnt <= '0;
            state <= S_WSYNC;
          end
        end
        S_WSYNC: begin
          lat_cnt <= lat_cnt + 1'b1;
          if (lat_end) state <= S_SYNC;
        end
        S_SYNC: if (buf_last) begin
          lat_cnt <= '0;
          state <= S_WDATA;
        end
        S_WDATA: begin
          lat_cnt <= lat_cnt + 1'b1;
          dcnt <= '0;
          if (lat_end) state <= S_DATA;
        end
        S_DATA: begin
          mem_ptr <= mem_ptr + 1'b1;
          dcnt <= dcnt + 1'b1;
          if (dcnt == unit_words - 1'b1) state <= S_GDES;
        end
        S_GDES: begin
          lat_cnt <= '0;
          state <= S_WDES;
        end
        S_WDES: begin
          lat_cnt <= lat_cnt + 1'b1;
          if (lat_end) state <= S_DES;
        end
        S_DES: begin
          if (op_q == OP_COPY) frame_idx <= frame_idx + 1'b1;
          else begin
            ch_idx <= ch_idx + 1'b1;
            off_q <= off_q + 32'(cur_len);
          end
          state <= S_NEXT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign done_o   = done_q;
  assign cfg_en_o = (state == S_SYNC) || (state == S_DATA) || (state == S_DES);
  assign cfg_wr_o = !((state == S_DATA) && (op_q == OP_COPY));
  always_comb begin
    if (state == S_DATA) cfg_wdata_o = (op_q == OP_CONFIG) ? data_word : '0;
    else if (buf_pop)    cfg_wdata_o = buf_head;
    else                 cfg_wdata_o = '0;
  end

  // R9: done is a lone pulse outside busy; the port is silent while not busy
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cfg_en_o);
  // R2: read cycles occur only within a copy
  p_read_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_o && !cfg_wr_o) |-> (op_q == OP_COPY));
  // R8: a start while busy leaves the latched operation untouched
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(base_q)));
endmodule

// File: tb/frame_reloc_ctrl_tb.sv
module frame_reloc_ctrl_tb;
  localparam int FW = 4;
  localparam int LAT = 2;
  localparam logic [31:0] SYNC = 32'hAA99_5566;
  localparam logic [31:0] RDC  = 32'h2800_6000;
  localparam logic [31:0] WRC  = 32'h3000_4000;
  localparam logic [31:0] DSY  = 32'h0000_000D;
  localparam int LOGN = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, op_i = 1'b0, opp_half_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [4:0] frame_cnt_i = '0;
  logic [2:0] chunk_num_i = '0;
  logic [23:0] chunk_len_i = '0;
  logic busy_o, done_o, cfg_en_o, cfg_wr_o;
  logic [31:0] cfg_wdata_o, cfg_rdata_i;

  always #10 clk = ~clk;

  frame_reloc_ctrl #(
    .FRAME_WORDS(FW), .MAX_FRAMES(16), .MAX_CHUNKS(4), .LEN_W(6), .STARTUP_LAT(LAT),
    .SYNC_WORD(SYNC), .READ_CMD(RDC), .WRITE_CMD(WRC), .DESYNC_WORD(DSY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .start_addr_i(start_addr_i), .frame_cnt_i(frame_cnt_i),
    .chunk_num_i(chunk_num_i), .chunk_len_i(chunk_len_i),
    .opp_half_i(opp_half_i), .busy_o(busy_o), .done_o(done_o),
    .cfg_en_o(cfg_en_o), .cfg_wr_o(cfg_wr_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_rdata_i(cfg_rdata_i)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  logic        lg_wr [LOGN];
  logic [31:0] lg_d  [LOGN];
  int          lg_t  [LOGN];
  int          lg_n = 0;
  logic [31:0] exp_mem [64];

  function automatic logic [31:0] rd_pat(input logic [31:0] a, input int w);
    return {a[15:0] ^ 16'hC35A, 8'h7E, 8'(w)};
  endfunction

  function automatic logic [31:0] flip(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = w[i];
    return r;
  endfunction

  // behavioural port model: captures the frame address after a mode word
  logic [31:0] m_addr = '0, m_prev = '0;
  int m_w = 0;
  assign cfg_rdata_i = (cfg_en_o && !cfg_wr_o) ? rd_pat(m_addr, m_w) : 32'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cfg_en_o) begin
      if (lg_n < LOGN) begin
        lg_wr[lg_n] = cfg_wr_o;
        lg_d[lg_n]  = cfg_wr_o ? cfg_wdata_o : cfg_rdata_i;
        lg_t[lg_n]  = cyc;
        lg_n = lg_n + 1;
      end
      if (cfg_wr_o) begin
        if (m_prev == RDC || m_prev == WRC) begin
          m_addr <= cfg_wdata_o;
          m_w <= 0;
        end
        m_prev <= cfg_wdata_o;
      end else begin
        m_w <= m_w + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_at(input int i, input logic wr, input logic [31:0] d, input string req);
    chk(i < lg_n && lg_wr[i] == wr && lg_d[i] == d, req, (i < lg_n) ? lg_d[i] : 32'hFFFF_FFFF, d);
  endtask

  task automatic run_op(input logic op, input logic [31:0] addr, input logic [4:0] cnt,
                        input logic [2:0] num, input logic [23:0] lens, input logic opp,
                        input int poke);
    int waited, n0;
    @(negedge clk);
    lg_n = 0;
    op_i = op; start_addr_i = addr; frame_cnt_i = cnt;
    chunk_num_i = num; chunk_len_i = lens; opp_half_i = opp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (done_o !== 1'b1 && waited < 5000) begin
      start_i = (poke > 0 && waited == poke);
      if (start_i) begin
        op_i = 1'b1; start_addr_i = 32'hDEAD_0000; chunk_num_i = 3'd1; chunk_len_i = 24'd1;
      end
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    chk(done_o === 1'b1, "R9 done seen", {31'd0, done_o}, 32'd1);
    chk(busy_o === 1'b0, "R9 busy low with done", {31'd0, busy_o}, 32'd0);
    n0 = lg_n;
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done one cycle", {31'd0, done_o}, 32'd0);
    repeat (4) @(negedge clk);
    chk(lg_n == n0 && !busy_o, "R8 R9 quiet after done", 32'(lg_n), 32'(n0));
  endtask

  task automatic check_copy(input logic [31:0] src, input int n);
    int i = 0;
    chk(lg_n == n * (FW + 4), "R2 copy length", 32'(lg_n), 32'(n * (FW + 4)));
    for (int f = 0; f < n; f++) begin
      expect_at(i, 1'b1, SYNC, "R2 sync");
      expect_at(i + 1, 1'b1, RDC, "R2 read mode");
      expect_at(i + 2, 1'b1, src + 32'(f), "R2 frame address");
      chk(lg_t[i + 3] - lg_t[i + 2] - 1 == LAT, "R3 data gap", 32'(lg_t[i + 3] - lg_t[i + 2] - 1), 32'(LAT));
      for (int w = 0; w < FW; w++) begin
        expect_at(i + 3 + w, 1'b0, rd_pat(src + 32'(f), w), "R2 read word");
        exp_mem[(f * FW + w) % 64] = rd_pat(src + 32'(f), w);
      end
      chk(lg_t[i + 3 + FW] - lg_t[i + 2 + FW] - 1 >= LAT, "R3 desync gap",
          32'(lg_t[i + 3 + FW] - lg_t[i + 2 + FW] - 1), 32'(LAT));
      expect_at(i + 3 + FW, 1'b1, DSY, "R2 desync");
      i += FW + 4;
    end
  endtask

  task automatic check_config(input logic [31:0] dst, input logic [2:0] num,
                              input logic [23:0] lens, input logic opp);
    int i = 0, off = 0, k = 0, len;
    for (int c = 0; c < num; c++) begin
      len = int'(lens[c*6 +: 6]);
      if (len == 0) continue;
      expect_at(i, 1'b1, SYNC, "R4 sync");
      expect_at(i + 1, 1'b1, WRC, "R4 write mode");
      expect_at(i + 2, 1'b1, dst + 32'(off), "R4 chunk address");
      chk(lg_t[i + 3] - lg_t[i + 2] - 1 == LAT, "R3 burst gap", 32'(lg_t[i + 3] - lg_t[i + 2] - 1), 32'(LAT));
      for (int w = 0; w < len * FW; w++) begin
        expect_at(i + 3 + w, 1'b1, opp ? flip(exp_mem[k % 64]) : exp_mem[k % 64],
                  opp ? "R6 reversed word" : "R5 stored word");
        k++;
      end
      expect_at(i + 3 + len * FW, 1'b1, DSY, "R4 desync");
      i += len * FW + 4;
      off += len;
    end
    chk(lg_n == i, "R4 burst length", 32'(lg_n), 32'(i));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy_o && !done_o && !cfg_en_o, "R1 reset state", {29'd0, busy_o, done_o, cfg_en_o}, 32'd0);
  endtask

  task automatic t_copy(input logic [31:0] src, input int n);
    run_op(1'b0, src, 5'(n), 3'd0, 24'd0, 1'b0, 0);
    check_copy(src, n);
  endtask

  task automatic t_config(input logic [31:0] dst, input logic [2:0] num,
                          input logic [23:0] lens, input logic opp);
    run_op(1'b1, dst, 5'd0, num, lens, opp, 0);
    check_config(dst, num, lens, opp);
  endtask

  task automatic t_empty();
    run_op(1'b0, 32'h10, 5'd0, 3'd0, 24'd0, 1'b0, 0);
    chk(lg_n == 0, "R7 zero frames idle", 32'(lg_n), 32'd0);
    run_op(1'b1, 32'h20, 5'd0, 3'd0, 24'd3, 1'b0, 0);
    chk(lg_n == 0, "R7 empty list idle", 32'(lg_n), 32'd0);
    run_op(1'b1, 32'h30, 5'd0, 3'd2, 24'd0, 1'b1, 0);
    chk(lg_n == 0, "R7 zero chunks idle", 32'(lg_n), 32'd0);
  endtask

  task automatic t_busy_ignore();
    run_op(1'b0, 32'h500, 5'd2, 3'd0, 24'd0, 1'b0, 5);
    check_copy(32'h500, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_copy(32'h100, 3);
    t_config(32'h200, 3'd2, {6'd0, 6'd0, 6'd1, 6'd2}, 1'b0);
    t_config(32'h300, 3'd3, {6'd0, 6'd2, 6'd0, 6'd1}, 1'b1);
    t_config(32'h400, 3'd1, {6'd0, 6'd0, 6'd0, 6'd3}, 1'b0);
    t_empty();
    t_busy_ignore();
    t_copy(32'h7F0, 16);
    t_config(32'hA00, 3'd4, {6'd6, 6'd0, 6'd4, 6'd6}, 1'b1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end
endmodule